// File: doc/BRIEF.md
# Universal Bidirectional Bus Register

This block joins two 18-bit buses, side A and side B, and carries data both ways. Each direction has its own storage word. A pass control makes the word transparent, so the output follows the input. When pass is low, the word is loaded on a rising edge of that direction's strobe, but only while the active-low strobe enable is asserted. Otherwise the word holds its value. When pass falls, the word keeps the last value that flowed through it.

The bus strobes arrive from outside the system clock domain. Each strobe goes through a synchronizer chain, and its rising edge is detected inside the block. A detected edge loads the word one system cycle later.

Tri-state pins are modelled as a data word plus a drive flag for each side. The flag is the inverse of that direction's active-low drive control. The flag only qualifies the data: the data word keeps showing the lane's contents while the flag is low. A synchronous reset clears both words. Reset does not touch the drive flags.

Top module: `ubr_bus_register`

## Requirements
- R1: While `ab_pass` is 1, `b_out` equals `a_in` in the same cycle, whatever `ab_strobe` and `ab_strobe_en_n` do.
- R2: With `ab_pass` 0 and `ab_strobe_en_n` 0, a 0-to-1 change of `ab_strobe` loads `a_in` into the A-to-B word. The new value is on `b_out` after the third rising system clock edge that follows the strobe change (two synchronizer stages plus one store cycle).
- R3: With `ab_pass` 0 and `ab_strobe_en_n` 1, `b_out` keeps its value however `ab_strobe` and `a_in` move.
- R4: With `ab_pass` 0, a strobe that stays 1 or stays 0, or that falls, does not load the word. A strobe that was already 1 when pass fell loads nothing until it has gone to 0 and risen again. Each rising edge gives exactly one load.
- R5: When `ab_pass` falls, the word keeps the `a_in` value seen at the last system clock edge where pass was 1.
- R6: `b_drive` equals the inverse of `ab_drive_n`, and `a_drive` equals the inverse of `ba_drive_n`. This holds during reset as well.
- R7: A 1 on a drive control clears only that side's drive flag. The word keeps loading and holding as usual, and it stays visible on the data output.
- R8: The B-to-A direction (`b_in` to `a_out`) follows R1 to R5, using `ba_pass`, `ba_strobe`, `ba_strobe_en_n` and `ba_drive_n`.
- R9: The controls of one direction never change the other direction's output.
- R10: A 1 on `rst` at a clock edge clears both words to zero. With pass low, `a_out` and `b_out` read zero after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 18 | Data arriving on side A |
| b_in | input | 18 | Data arriving on side B |
| ab_pass | input | 1 | A-to-B transparent control |
| ab_strobe | input | 1 | A-to-B bus strobe (asynchronous) |
| ab_strobe_en_n | input | 1 | A-to-B strobe enable, active low |
| ab_drive_n | input | 1 | Side B drive control, active low |
| ba_pass | input | 1 | B-to-A transparent control |
| ba_strobe | input | 1 | B-to-A bus strobe (asynchronous) |
| ba_strobe_en_n | input | 1 | B-to-A strobe enable, active low |
| ba_drive_n | input | 1 | Side A drive control, active low |
| b_out | output | 18 | Data toward side B |
| b_drive | output | 1 | Side B drive flag |
| a_out | output | 18 | Data toward side A |
| a_drive | output | 1 | Side A drive flag |

## Verification
The hardest case to reach is a strobe that is already high when pass falls. In that case the block must ignore the level and wait for a fresh rising edge. The stimulus gets there in three steps. First it holds the strobe high through a transparent phase until the synchronizer has settled. Then it drops pass and changes the input while the strobe stays high, and checks that nothing loads. Finally it lowers and raises the strobe, and checks that the load lands after exactly the third system edge. A further sequence turns off a side's drive and then performs a load, which shows that the stored word keeps changing behind a disabled side.

// File: rtl/ubr_pkg.sv
package ubr_pkg;

  // How one direction's storage word behaves in the current cycle.
  typedef enum logic [1:0] {
    MODE_PASS   = 2'd0,  // transparent: the word tracks its input
    MODE_STROBE = 2'd1,  // loads on a detected strobe rising edge
    MODE_FROZEN = 2'd2   // strobe enable is off: the word holds
  } lane_mode_e;

  function automatic lane_mode_e lane_mode(input logic pass, input logic strobe_en_n);
    if (pass)             return MODE_PASS;
    else if (!strobe_en_n) return MODE_STROBE;
    else                  return MODE_FROZEN;
  endfunction

  // A rising edge is a high sample that follows a low one.
  function automatic logic rise_of(input logic now_lvl, input logic before_lvl);
    return now_lvl & ~before_lvl;
  endfunction

endpackage

// File: rtl/ubr_strobe_sync.sv
module ubr_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_raw,
  output logic strobe_rise
);
  import ubr_pkg::*;

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain;
  logic              seen;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= strobe_raw;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) seen <= 1'b0;
    else     seen <= chain[LAST];
  end

  assign strobe_rise = rise_of(chain[LAST], seen);

endmodule

// File: rtl/ubr_lane.sv
module ubr_lane #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  input  logic         pass,
  input  logic         strobe_en_n,
  input  logic         strobe_rise,
  input  logic         drive_n,
  output logic [W-1:0] dout,
  output logic         drive,
  output logic         store_evt
);
  import ubr_pkg::*;

  lane_mode_e   mode;
  logic [W-1:0] held;
  logic         load;

  assign mode      = lane_mode(pass, strobe_en_n);
  assign store_evt = (mode == MODE_STROBE) && strobe_rise;
  assign load      = (mode == MODE_PASS) || store_evt;

  always_ff @(posedge clk) begin
    if (rst)       held <= '0;
    else if (load) held <= din;
  end

  // Transparent path bypasses the register; otherwise show the held word.
  assign dout  = (mode == MODE_PASS) ? din : held;
  assign drive = ~drive_n;

endmodule

// File: rtl/ubr_bus_register.sv
module ubr_bus_register #(
  parameter int W           = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         ab_pass,
  input  logic         ab_strobe,
  input  logic         ab_strobe_en_n,
  input  logic         ab_drive_n,
  input  logic         ba_pass,
  input  logic         ba_strobe,
  input  logic         ba_strobe_en_n,
  input  logic         ba_drive_n,
  output logic [W-1:0] b_out,
  output logic         b_drive,
  output logic [W-1:0] a_out,
  output logic         a_drive
);

  // Named internal events, visible to the bound checker.
  logic ab_rise, ba_rise;
  logic ab_store, ba_store;

  ubr_strobe_sync #(.STAGES(SYNC_STAGES)) u_ab_sync (
    .clk(clk), .rst(rst), .strobe_raw(ab_strobe), .strobe_rise(ab_rise)
  );

  ubr_strobe_sync #(.STAGES(SYNC_STAGES)) u_ba_sync (
    .clk(clk), .rst(rst), .strobe_raw(ba_strobe), .strobe_rise(ba_rise)
  );

  ubr_lane #(.W(W)) u_ab_lane (
    .clk(clk), .rst(rst), .din(a_in), .pass(ab_pass),
    .strobe_en_n(ab_strobe_en_n), .strobe_rise(ab_rise), .drive_n(ab_drive_n),
    .dout(b_out), .drive(b_drive), .store_evt(ab_store)
  );

  ubr_lane #(.W(W)) u_ba_lane (
    .clk(clk), .rst(rst), .din(b_in), .pass(ba_pass),
    .strobe_en_n(ba_strobe_en_n), .strobe_rise(ba_rise), .drive_n(ba_drive_n),
    .dout(a_out), .drive(a_drive), .store_evt(ba_store)
  );

endmodule

// File: rtl/ubr_checker.sv
module ubr_checker #(
  parameter int W = 18
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic [W-1:0] a_out,
  input logic [W-1:0] b_out,
  input logic         ab_pass,
  input logic         ba_pass,
  input logic         ab_strobe_en_n,
  input logic         ba_strobe_en_n,
  input logic         ab_evt,
  input logic         ba_evt,
  input logic         ab_st,
  input logic         ba_st
);

  assert_pass_R1: assert property (@(posedge clk) disable iff (rst)
    ab_pass |-> b_out == a_in);

  assert_capture_R2: assert property (@(posedge clk) disable iff (rst)
    (ab_st && !ab_pass) ##1 !ab_pass |-> b_out == $past(a_in));

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!ab_pass && ab_strobe_en_n) ##1 !ab_pass |-> $stable(b_out));

  assert_single_R4: assert property (@(posedge clk) disable iff (rst)
    ab_evt |=> !ab_evt);

  assert_ba_pass_R8: assert property (@(posedge clk) disable iff (rst)
    ba_pass |-> a_out == b_in);

  assert_ba_capture_R8: assert property (@(posedge clk) disable iff (rst)
    (ba_st && !ba_pass) ##1 !ba_pass |-> a_out == $past(b_in));

  assert_ba_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!ba_pass && ba_strobe_en_n) ##1 !ba_pass |-> $stable(a_out));

  assert_ba_single_R8: assert property (@(posedge clk) disable iff (rst)
    ba_evt |=> !ba_evt);

  assert_clear_R10: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && !ab_pass && !ba_pass) |-> (a_out == '0 && b_out == '0));

endmodule

bind ubr_bus_register ubr_checker #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .a_out(a_out), .b_out(b_out),
  .ab_pass(ab_pass), .ba_pass(ba_pass),
  .ab_strobe_en_n(ab_strobe_en_n), .ba_strobe_en_n(ba_strobe_en_n),
  .ab_evt(ab_rise), .ba_evt(ba_rise), .ab_st(ab_store), .ba_st(ba_store)
);

// File: tb/tb_ubr_bus_register.sv
module tb_ubr_bus_register;
  localparam int W = 18;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic ab_pass = 0, ab_strobe = 0, ab_strobe_en_n = 1, ab_drive_n = 0;
  logic ba_pass = 0, ba_strobe = 0, ba_strobe_en_n = 1, ba_drive_n = 1;
  logic [W-1:0] a_out, b_out;
  logic a_drive, b_drive;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;  // 125 MHz

  ubr_bus_register #(.W(W), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
    .ab_pass(ab_pass), .ab_strobe(ab_strobe), .ab_strobe_en_n(ab_strobe_en_n),
    .ab_drive_n(ab_drive_n),
    .ba_pass(ba_pass), .ba_strobe(ba_strobe), .ba_strobe_en_n(ba_strobe_en_n),
    .ba_drive_n(ba_drive_n),
    .b_out(b_out), .b_drive(b_drive), .a_out(a_out), .a_drive(a_drive)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk1(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Behavioural reference: a word per direction, plus a history of strobe
  // samples. A load happens at the edge where the sample from two edges back
  // is high and the one from three edges back is low.
  logic [W-1:0] m_ab = '0, m_ba = '0;
  bit hab[$];
  bit hba[$];
  bit rise_ab, rise_ba;

  always @(posedge clk) begin
    rise_ab = hab.size() >= 3 && hab[hab.size()-2] && !hab[hab.size()-3];
    rise_ba = hba.size() >= 3 && hba[hba.size()-2] && !hba[hba.size()-3];
    if (rst)                               m_ab = '0;
    else if (ab_pass)                      m_ab = a_in;
    else if (!ab_strobe_en_n && rise_ab)   m_ab = a_in;
    if (rst)                               m_ba = '0;
    else if (ba_pass)                      m_ba = b_in;
    else if (!ba_strobe_en_n && rise_ba)   m_ba = b_in;
    hab.push_back(rst ? 1'b0 : ab_strobe);
    hba.push_back(rst ? 1'b0 : ba_strobe);
    if (hab.size() > 6) void'(hab.pop_front());
    if (hba.size() > 6) void'(hba.pop_front());
    #2;
    chk("R9 model b_out", b_out, ab_pass ? a_in : m_ab);
    chk("R9 model a_out", a_out, ba_pass ? b_in : m_ba);
    chk1("R6 b_drive", b_drive, ~ab_drive_n);
    chk1("R6 a_drive", a_drive, ~ba_drive_n);
    checks++;
    if (a_drive && b_drive) begin
      fails++;
      $display("FAIL R6 contention actual=%b%b expected=not both", a_drive, b_drive);
    end
  end

  initial begin
    step(3);
    chk1("R6 drive during reset", b_drive, 1'b1);
    rst = 0;
    step(1);
    chk("R10 reset b_out", b_out, '0);
    chk("R10 reset a_out", a_out, '0);

    // R1 transparent, with strobe activity ignored
    ab_pass = 1; a_in = 18'h2A5A5; ab_strobe_en_n = 0; ab_strobe = 1;
    step(1);
    chk("R1 pass", b_out, 18'h2A5A5);
    a_in = 18'h0F0F0; ab_strobe = 0;
    step(1);
    chk("R1 pass follows", b_out, 18'h0F0F0);
    step(3);

    // R5 pass falls: keep last transparent value
    a_in = 18'h15A5A;
    step(1);
    ab_pass = 0; a_in = 18'h3FFFF;
    step(1);
    chk("R5 latch on pass fall", b_out, 18'h15A5A);

    // R2 strobe capture, latency of three system edges
    a_in = 18'h3F00F; ab_strobe = 1;
    step(2);
    chk("R2 not yet loaded", b_out, 18'h15A5A);
    step(1);
    chk("R2 loaded", b_out, 18'h3F00F);
    ab_strobe = 0;
    step(4);

    // R3 strobe enable off: hold
    ab_strobe_en_n = 1; a_in = 18'h00FF3; ab_strobe = 1;
    step(3);
    ab_strobe = 0;
    step(3);
    chk("R3 hold with enable off", b_out, 18'h3F00F);

    // R4 strobe already high when pass falls
    ab_strobe_en_n = 0; ab_pass = 1; ab_strobe = 1; a_in = 18'h12345;
    step(4);
    ab_pass = 0; a_in = 18'h2BCDE;
    step(5);
    chk("R4 steady high no load", b_out, 18'h12345);
    ab_strobe = 0;
    step(5);
    chk("R4 falling edge no load", b_out, 18'h12345);
    ab_strobe = 1;
    step(3);
    chk("R4 fresh rise loads", b_out, 18'h2BCDE);

    // R7 drive off keeps storage working
    ab_drive_n = 1; ab_strobe_en_n = 1; a_in = 18'h01111;
    step(2);
    chk1("R7 drive flag off", b_drive, 1'b0);
    chk("R7 word kept while off", b_out, 18'h2BCDE);
    ab_strobe_en_n = 0; ab_strobe = 0;
    step(3);
    ab_strobe = 1;
    step(3);
    chk("R7 load while drive off", b_out, 18'h01111);

    // R8 B-to-A direction, R9 A-to-B untouched
    ba_drive_n = 0; ba_pass = 1; b_in = 18'h2D2D2;
    step(1);
    chk("R8 ba pass", a_out, 18'h2D2D2);
    chk("R9 ab untouched", b_out, 18'h01111);
    ba_pass = 0; ba_strobe_en_n = 0; b_in = 18'h1C3C3; ba_strobe = 1;
    step(3);
    chk("R8 ba capture", a_out, 18'h1C3C3);
    chk("R9 ab untouched by ba strobe", b_out, 18'h01111);
    ba_strobe = 0;
    step(3);

    // R10 reset mid-run
    rst = 1;
    step(2);
    chk1("R6 a_drive during reset", a_drive, 1'b1);
    rst = 0;
    step(1);
    chk("R10 clears b word", b_out, '0);
    chk("R10 clears a word", a_out, '0);
    step(2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule